// File: doc/BRIEF.md
# Card Data FIFO with Watermark Requests

This block is the word buffer that sits between a processor-visible data register and the serial card data path of a storage-card host controller. Software talks to it through a small register window of five word registers: a control word, a status word, a threshold word, a raw request word and the data port. The card side, which is a serializer or a DMA engine, moves words through plain push and pop strobes. On a read transfer the card pushes and software drains the data port. On a write transfer software fills the data port and the card pops.

The FIFO publishes its fill level in the status word. It also raises two request bits that tell software when to move data. The receive request is raised while the fill level is above the receive watermark. The transmit request is raised while the fill level is at or below the transmit watermark. After reset the receive watermark holds DEPTH-1, so a driver can read that field to learn how deep the FIFO is. Writing the reset bit of the control word empties the FIFO through a short flush sequence built on three states:
- RUN: normal operation.
- FLUSH: one cycle in which the pointers are cleared.
- RELEASE: one cycle in which the buffer settles.

The transitions are RUN→FLUSH when the reset bit is written as 1, FLUSH→RELEASE unconditionally, and RELEASE→RUN unconditionally. The control bit reads back as 1 until the sequence has returned to RUN.

Register word indices on `reg_addr`: 0 control, 1 status, 2 threshold, 3 raw requests, 4 data.

Top module: `card_data_fifo`

## Requirements
- R1: After reset, the status word reads empty (bit 0 = 1), full (bit 1) = 0 and count (bits starting at 8) = 0. The threshold word reads receive watermark (bits starting at 16) = DEPTH-1, transmit watermark (bits starting at 0) = 0 and burst (bits 30:28) = 0. The control word reads 0.
- R2: Words written to the data port (index 4) are read back from the data port in the same order. The count field tracks the number of stored words.
- R3: With DEPTH words stored, status bit 1 (full) is 1. A further push is dropped, leaves the contents unchanged and sets overflow bit 3 of the raw request word.
- R4: A data-port read while the FIFO is empty returns the word returned by the previous successful data-port read, sets underflow bit 2 of the raw request word and leaves the count at 0.
- R5: A push and a pop accepted in the same cycle leave the count unchanged. This holds for a card push with a data-port read, and for a data-port write with a card pop.
- R6: Raw request bit 0 (receive request) sets one cycle after the count is strictly greater than the receive watermark. It does not set when the count equals the watermark.
- R7: Raw request bit 1 (transmit request) sets one cycle after the count is less than or equal to the transmit watermark.
- R8: Writing the raw request word clears each bit written as 1; bits written as 0 are untouched. A request whose condition still holds sets again on the next cycle.
- R9: Writing control bit 0 as 1 runs RUN→FLUSH→RELEASE→RUN. Control bit 0 reads 1 for exactly two cycles, then 0. The FIFO is empty afterwards, and pushes or pops during the two busy cycles are ignored.
- R10: The threshold word is writable. Each watermark field keeps its low log2(DEPTH) bits and the burst field keeps 3 bits; all other bits read 0.
- R11: When a data-port write and a card push occur in the same cycle, only the data-port word is stored.
- R12: A card push stores `card_push_data`. `card_pop_data` always presents the oldest stored word, and `card_pop` removes it. `card_empty` and `card_full` mirror the status flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops only at the data port) |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational on reg_addr |
| card_push | input | 1 | Card-side push strobe |
| card_push_data | input | 32 | Card-side word to store |
| card_pop | input | 1 | Card-side pop strobe |
| card_pop_data | output | 32 | Oldest stored word |
| card_full | output | 1 | FIFO holds DEPTH words |
| card_empty | output | 1 | FIFO holds no words |

## Verification
The bench builds the block with DEPTH = 8. This makes the count field 4 bits wide and each watermark 3 bits wide. A full FIFO is then reached in eight writes, so the overflow drop, the full flag and the wrap of both pointers are all exercised in a short run. The narrow watermark fields also let one all-ones threshold write show the masking of R10. With the watermarks set to 2 (receive) and 1 (transmit), the bench lands on each request boundary by writing and draining single words.

// File: rtl/cdf_pkg.sv
package cdf_pkg;

    // Register window word indices
    typedef enum logic [2:0] {
        RA_CTRL = 3'd0,
        RA_STAT = 3'd1,
        RA_THR  = 3'd2,
        RA_RAW  = 3'd3,
        RA_DATA = 3'd4
    } reg_addr_e;

    // Flush sequencer states
    typedef enum logic [1:0] {
        ST_RUN     = 2'd0,
        ST_FLUSH   = 2'd1,
        ST_RELEASE = 2'd2
    } flush_st_e;

    // Raw request bit positions
    localparam int IRQ_RXREQ = 0;
    localparam int IRQ_TXREQ = 1;
    localparam int IRQ_UNDER = 2;
    localparam int IRQ_OVER  = 3;
    localparam int IRQ_W     = 4;

    // Status word layout
    localparam int STAT_EMPTY   = 0;
    localparam int STAT_FULL    = 1;
    localparam int STAT_CNT_LSB = 8;

    // Threshold word layout
    localparam int THR_TX_LSB    = 0;
    localparam int THR_RX_LSB    = 16;
    localparam int THR_BURST_LSB = 28;
    localparam int BURST_W       = 3;

endpackage

// File: rtl/cdf_store.sv
module cdf_store #(
    parameter int DW    = 32,
    parameter int DEPTH = 16,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [DW-1:0] head,
    output logic [CW-1:0] count,
    output logic          empty,
    output logic          full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DW-1:0] mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] cnt_q;
    logic          push_ok, pop_ok;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign empty   = (cnt_q == '0);
    assign full    = (cnt_q == CW'(DEPTH));
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign head    = mem[rd_ptr];
    assign count   = cnt_q;

    always_ff @(posedge clk) begin
        if (push_ok && !clear) begin
            mem[wr_ptr] <= push_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt_q  <= '0;
        end else begin
            if (push_ok) wr_ptr <= bump(wr_ptr);
            if (pop_ok)  rd_ptr <= bump(rd_ptr);
            unique case ({push_ok, pop_ok})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    // R2
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));
    // R3
    full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop && !clear) |=> $stable(count));
    // R5
    pushpop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop && !empty && !full && !clear) |=> $stable(count));
    // R9
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> empty);

endmodule

// File: rtl/cdf_flush_fsm.sv
module cdf_flush_fsm
    import cdf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic clear,
    output logic busy
);
    flush_st_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:     if (start) state_d = ST_FLUSH;
            ST_FLUSH:   state_d = ST_RELEASE;
            ST_RELEASE: state_d = ST_RUN;
            default:    state_d = ST_RUN;
        endcase
    end

    always_comb begin
        clear = 1'b0;
        busy  = 1'b1;
        unique case (state_q)
            ST_RUN:     busy  = 1'b0;
            ST_FLUSH:   clear = 1'b1;
            ST_RELEASE: clear = 1'b0;
            default:    busy  = 1'b0;
        endcase
    end

    // R9
    flush_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FLUSH) |=> (state_q == ST_RELEASE));
    // R9
    release_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RELEASE) |=> (state_q == ST_RUN));

endmodule

// File: rtl/cdf_irq.sv
module cdf_irq
    import cdf_pkg::*;
#(
    parameter int CW = 5,
    parameter int AW = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CW-1:0]     count,
    input  logic [AW-1:0]     rx_wm,
    input  logic [AW-1:0]     tx_wm,
    input  logic              under_ev,
    input  logic              over_ev,
    input  logic              clr_we,
    input  logic [IRQ_W-1:0]  clr_mask,
    output logic [IRQ_W-1:0]  raw
);
    logic [IRQ_W-1:0] set_vec;

    always_comb begin
        set_vec            = '0;
        set_vec[IRQ_RXREQ] = (count > CW'(rx_wm));
        set_vec[IRQ_TXREQ] = (count <= CW'(tx_wm));
        set_vec[IRQ_UNDER] = under_ev;
        set_vec[IRQ_OVER]  = over_ev;
    end

    for (genvar b = 0; b < IRQ_W; b++) begin : g_bit
        logic q;
        always_ff @(posedge clk) begin
            if (!rst_n) q <= 1'b0;
            else        q <= (q && !(clr_we && clr_mask[b])) || set_vec[b];
        end
        assign raw[b] = q;
    end

    // R6
    rx_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (count > CW'(rx_wm)) |=> raw[IRQ_RXREQ]);
    // R7
    tx_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (count <= CW'(tx_wm)) |=> raw[IRQ_TXREQ]);
    // R8
    w1c_under_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we && clr_mask[IRQ_UNDER] && !under_ev) |=> !raw[IRQ_UNDER]);

endmodule

// File: rtl/card_data_fifo.sv
module card_data_fifo
    import cdf_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [2:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        card_push,
    input  logic [31:0] card_push_data,
    input  logic        card_pop,
    output logic [31:0] card_pop_data,
    output logic        card_full,
    output logic        card_empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [AW-1:0]      rx_wm_q, tx_wm_q;
    logic [BURST_W-1:0] burst_q;
    logic [31:0]        last_rd_q, head;
    logic [CW-1:0]      count;
    logic               empty, full, busy, clear;
    logic               sw_data_wr, sw_data_rd, push_req, pop_req;
    logic [31:0]        push_word;
    logic [IRQ_W-1:0]   raw;

    assign sw_data_wr = reg_wr && (reg_addr == RA_DATA);
    assign sw_data_rd = reg_rd && (reg_addr == RA_DATA);
    assign push_req   = !busy && (sw_data_wr || card_push);
    assign pop_req    = !busy && (sw_data_rd || card_pop);
    assign push_word  = sw_data_wr ? reg_wdata : card_push_data;

    cdf_flush_fsm u_flush (
        .clk   (clk),
        .rst_n (rst_n),
        .start (reg_wr && (reg_addr == RA_CTRL) && reg_wdata[0]),
        .clear (clear),
        .busy  (busy)
    );

    cdf_store #(.DW(32), .DEPTH(DEPTH), .CW(CW)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (clear),
        .push      (push_req),
        .push_data (push_word),
        .pop       (pop_req),
        .head      (head),
        .count     (count),
        .empty     (empty),
        .full      (full)
    );

    cdf_irq #(.CW(CW), .AW(AW)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .count    (count),
        .rx_wm    (rx_wm_q),
        .tx_wm    (tx_wm_q),
        .under_ev (pop_req && empty),
        .over_ev  (push_req && full),
        .clr_we   (reg_wr && (reg_addr == RA_RAW)),
        .clr_mask (reg_wdata[IRQ_W-1:0]),
        .raw      (raw)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_wm_q <= AW'(DEPTH - 1);
            tx_wm_q <= '0;
            burst_q <= '0;
        end else if (reg_wr && (reg_addr == RA_THR)) begin
            rx_wm_q <= reg_wdata[THR_RX_LSB +: AW];
            tx_wm_q <= reg_wdata[THR_TX_LSB +: AW];
            burst_q <= reg_wdata[THR_BURST_LSB +: BURST_W];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                             last_rd_q <= '0;
        else if (sw_data_rd && !busy && !empty) last_rd_q <= head;
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr_e'(reg_addr))
            RA_CTRL: reg_rdata[0] = busy;
            RA_STAT: begin
                reg_rdata[STAT_EMPTY]             = empty;
                reg_rdata[STAT_FULL]              = full;
                reg_rdata[STAT_CNT_LSB +: CW]     = count;
            end
            RA_THR: begin
                reg_rdata[THR_TX_LSB +: AW]       = tx_wm_q;
                reg_rdata[THR_RX_LSB +: AW]       = rx_wm_q;
                reg_rdata[THR_BURST_LSB +: BURST_W] = burst_q;
            end
            RA_RAW:  reg_rdata[IRQ_W-1:0] = raw;
            RA_DATA: reg_rdata = empty ? last_rd_q : head;
            default: reg_rdata = '0;
        endcase
    end

    assign card_pop_data = head;
    assign card_full     = full;
    assign card_empty    = empty;

    // R4
    underflow_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_data_rd && empty && !busy) |=> raw[IRQ_UNDER]);
    // R3
    overflow_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_data_wr && full && !busy) |=> raw[IRQ_OVER]);
    // R11
    push_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_data_wr && card_push && !busy && !full && !pop_req)
        |=> (count == $past(count) + 1'b1));

endmodule

// File: tb/card_data_fifo_tb_top.sv
`timescale 1ns/100ps
module card_data_fifo_tb_top;
    import cdf_pkg::*;

    localparam int DEPTH = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic        card_push = 1'b0, card_pop = 1'b0;
    logic [31:0] card_push_data = '0, card_pop_data;
    logic        card_full, card_empty;

    int n_cmp = 0, n_bad = 0;
    bit done = 0;
    logic [31:0] sb_q[$];

    always #2.5 clk = ~clk;

    card_data_fifo #(.DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .card_push(card_push), .card_push_data(card_push_data),
        .card_pop(card_pop), .card_pop_data(card_pop_data),
        .card_full(card_full), .card_empty(card_empty)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic data_read(output logic [31:0] d);
        @(negedge clk);
        reg_addr = RA_DATA; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    // driver: write the data port and record the expected word
    task automatic drv_write(input logic [31:0] w);
        reg_write(RA_DATA, w);
        if (sb_q.size() < DEPTH) sb_q.push_back(w);
    endtask

    // monitor: read the data port and compare with the oldest expected word
    task automatic mon_read(input string req);
        logic [31:0] d, e;
        data_read(d);
        e = (sb_q.size() > 0) ? sb_q.pop_front() : 32'hDEAD_BEEF;
        check(req, d, e);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog got=%h exp=%h", 32'd0, 32'd1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        idle(3);
        rst_n = 1'b1;

        // R1 reset state
        reg_read(RA_STAT, d); check("R1 status", d, 32'h0000_0001);
        reg_read(RA_THR, d);  check("R1 threshold", d, 32'h0007_0000);
        reg_read(RA_CTRL, d); check("R1 control", d, 32'h0);
        idle(2);
        reg_read(RA_RAW, d);  check("R7 tx request at reset", d, 32'h2);

        // R10 threshold masking and write
        reg_write(RA_THR, 32'hFFFF_FFFF);
        reg_read(RA_THR, d);  check("R10 masked fields", d, 32'h7007_0007);
        reg_write(RA_THR, 32'h5002_0001);
        reg_read(RA_THR, d);  check("R10 readback", d, 32'h5002_0001);

        // R8 clear while condition persists
        reg_write(RA_RAW, 32'hF); idle(2);
        reg_read(RA_RAW, d);  check("R8 tx re-sets", d, 32'h2);

        // R6/R7 boundaries at count 2
        drv_write(32'hA000_0001); drv_write(32'hA000_0002); idle(2);
        reg_write(RA_RAW, 32'hF); idle(2);
        reg_read(RA_RAW, d);  check("R6 R7 boundary count=2", d, 32'h0);
        reg_read(RA_STAT, d); check("R2 count 2", d, 32'h0000_0200);
        drv_write(32'hA000_0003); idle(2);
        reg_read(RA_RAW, d);  check("R6 rx request count=3", d, 32'h1);
        reg_write(RA_RAW, 32'h0); idle(1);
        reg_read(RA_RAW, d);  check("R8 zero write no effect", d, 32'h1);

        mon_read("R2 order 1"); mon_read("R2 order 2");
        idle(1);
        reg_write(RA_RAW, 32'hF); idle(2);
        reg_read(RA_RAW, d);  check("R8 cleared rx, R7 tx at count=1", d, 32'h2);
        mon_read("R2 order 3");

        // R4 underflow
        data_read(d);         check("R4 last value on empty read", d, 32'hA000_0003);
        idle(1);
        reg_read(RA_RAW, d);  check("R4 underflow bit", d & 32'h4, 32'h4);
        reg_read(RA_STAT, d); check("R4 count stays 0", d, 32'h0000_0001);
        reg_write(RA_RAW, 32'hF);

        // R3 full and overflow
        for (int i = 0; i < DEPTH; i++) drv_write(32'hB000_0000 + i);
        reg_read(RA_STAT, d); check("R3 full status", d, 32'h0000_0802);
        drv_write(32'hB000_00FF);
        idle(1);
        reg_read(RA_RAW, d);  check("R3 overflow bit", d & 32'h8, 32'h8);
        reg_read(RA_STAT, d); check("R3 count held", d, 32'h0000_0802);
        for (int i = 0; i < DEPTH; i++) mon_read("R3 contents");
        reg_read(RA_STAT, d); check("R3 drained", d, 32'h0000_0001);

        // R5 / R12 simultaneous push and pop
        drv_write(32'hC000_0000); drv_write(32'hC000_0001);
        @(negedge clk);
        reg_addr = RA_DATA; reg_rd = 1'b1;
        card_push = 1'b1; card_push_data = 32'hC000_0002;
        #1 d = reg_rdata;
        check("R5 read during card push", d, sb_q.pop_front());
        sb_q.push_back(32'hC000_0002);
        @(negedge clk);
        reg_rd = 1'b0; card_push = 1'b0;
        reg_read(RA_STAT, d); check("R5 count unchanged A", d, 32'h0000_0200);

        @(negedge clk);
        check("R12 card_pop_data head", card_pop_data, sb_q.pop_front());
        card_pop = 1'b1; reg_addr = RA_DATA; reg_wr = 1'b1; reg_wdata = 32'hC000_0003;
        sb_q.push_back(32'hC000_0003);
        @(negedge clk);
        card_pop = 1'b0; reg_wr = 1'b0;
        reg_read(RA_STAT, d); check("R5 count unchanged B", d, 32'h0000_0200);
        check("R12 card_empty low", {31'd0, card_empty}, 32'h0);

        // R11 register write wins over card push
        @(negedge clk);
        reg_addr = RA_DATA; reg_wr = 1'b1; reg_wdata = 32'hC000_0004;
        card_push = 1'b1; card_push_data = 32'hC000_0005;
        sb_q.push_back(32'hC000_0004);
        @(negedge clk);
        reg_wr = 1'b0; card_push = 1'b0;
        reg_read(RA_STAT, d); check("R11 one word stored", d, 32'h0000_0300);
        mon_read("R12 card word"); mon_read("R5 sw word"); mon_read("R11 sw word kept");
        reg_read(RA_STAT, d); check("R11 card word dropped", d, 32'h0000_0001);

        // R9 flush sequence
        drv_write(32'hD000_0000); drv_write(32'hD000_0001); drv_write(32'hD000_0002);
        reg_write(RA_CTRL, 32'h1);
        reg_addr = RA_CTRL; card_push = 1'b1; card_push_data = 32'hD000_00AA;
        #1 check("R9 ctrl busy cycle 1", reg_rdata, 32'h1);
        @(negedge clk);
        card_push = 1'b0;
        #1 check("R9 ctrl busy cycle 2", reg_rdata, 32'h1);
        @(negedge clk);
        #1 check("R9 ctrl self-clear", reg_rdata, 32'h0);
        reg_read(RA_STAT, d); check("R9 empty after flush", d, 32'h0000_0001);
        check("R12 card_empty after flush", {31'd0, card_empty}, 32'h1);
        sb_q.delete();

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule